// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Word Error Tags

This block receives asynchronous serial frames on a single line, timing each bit from a 16x oversampling tick supplied from outside. The frame format can be changed at run time: 5 to 9 data bits, optional even or odd parity, and one or two stop bits. Every received frame becomes one 16-bit word. The word holds the data together with a parity-error tag and a framing-error tag. A line held low for a whole frame (a break) shows up as a framing error with zero data. A break is reported once and is not reported again until the line has gone high.

Finished words go into a two-entry buffer. The buffer is drained over a valid/ready stream. `rx_valid` stays high while any word is held. When `rx_valid` is high and `rx_ready` is low, `rx_word` keeps the same value. The word at the head is removed on the rising clock edge where both signals are high. A frame that completes while the buffer is full is dropped and sets a sticky overflow flag. Reception is controlled by an enable strobe and a disable strobe.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset `rx_valid` and `ovf_flag` are low and the receiver is off, so no frame is captured until `cmd_en` is pulsed.
- R2: A `cmd_en` pulse turns reception on and a `cmd_dis` pulse turns it off. When both are pulsed in the same cycle, the disable takes effect. While reception is off, frames on the line store nothing.
- R3: A falling edge starts a frame only if the line is still low at the mid-bit sample, 8 ticks after the edge. A shorter low pulse is discarded and the receiver returns to idle. Every later bit is sampled 16 ticks after the one before it.
- R4: `cfg_dbits` holds the word length minus 3, so codes 2 to 6 give 5 to 9 data bits. Lower codes are treated as 5 bits and higher codes as 9 bits. Data arrives LSB first. Word layout: bits 8:0 hold the data, with unused upper data bits zero; bit 14 is the parity-error tag; bit 15 is the framing-error tag; bits 13:9 are zero.
- R5: `cfg_par` codes are 0 for none, 2 for even and 3 for odd; code 1 also means none. Parity is computed over the configured data bits only. A mismatch sets bit 14 of that word. Bit 14 is never set when parity is off.
- R6: A low first stop bit sets bit 15. When `cfg_stop2` is 1, the second stop bit is skipped without being checked, and a low level there neither tags the word nor starts a new frame.
- R7: A break, meaning the line is low from the start bit through the first stop bit, gives exactly one word with value 0x8000 (for a format without parity). The receiver then waits for the line to return high before it accepts a new start bit.
- R8: The buffer holds two words and hands them out in arrival order. While `rx_valid` is high and `rx_ready` is low, `rx_word` is held stable.
- R9: A frame that completes while both entries are full is discarded and sets `ovf_flag`. A set flag stays high until an `ovf_clr` pulse. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line; idles high |
| cfg_dbits | input | 4 | Word length minus 3 |
| cfg_par | input | 2 | Parity mode: 0 none, 2 even, 3 odd |
| cfg_stop2 | input | 1 | Two stop bits; only the first is checked |
| cmd_en | input | 1 | Strobe that turns reception on |
| cmd_dis | input | 1 | Strobe that turns reception off; wins over `cmd_en` |
| rx_word | output | 16 | Head word: data 8:0, parity tag 14, framing tag 15 |
| rx_valid | output | 1 | At least one word is buffered |
| rx_ready | input | 1 | Consumer takes the head word when `rx_valid` is high |
| ovf_flag | output | 1 | Sticky flag: a frame was lost to a full buffer |
| ovf_clr | input | 1 | Strobe that clears `ovf_flag` |

## Verification
The bench builds the block with its defaults: an oversampling rate of 16 and a buffer depth of 2. With a depth of 2, the third frame sent without draining is enough to reach the overflow path and the full-buffer hold. `os_tick` pulses every fourth clock, so one bit lasts 64 clocks. This leaves several clocks between the synchronised line and each mid-bit sample. It also makes a 4-tick glitch short enough to fail start qualification. The bench reaches both ends of the word-length range (5 and 9 bits), both parity senses, and the two-stop mode with a low second stop.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  localparam int WORD_W   = 16;
  localparam int DATA_W   = 9;
  localparam int PERR_POS = 14;
  localparam int FERR_POS = 15;

  typedef logic [WORD_W-1:0] rx_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_SKIP, S_HOLD
  } rx_state_e;

  function automatic rx_word_t pack_word(input logic [DATA_W-1:0] d,
                                         input logic pe, input logic fe);
    rx_word_t w;
    w = '0;
    w[DATA_W-1:0] = d;
    w[PERR_POS]   = pe;
    w[FERR_POS]   = fe;
    return w;
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
`timescale 1ns/1ps
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       line,
  input  logic [3:0] cfg_dbits,
  input  logic [1:0] cfg_par,
  input  logic       cfg_stop2,
  output logic       done,
  output rx_word_t   word
);
  localparam int CW   = $clog2(OS_RATE);
  localparam int HALF = OS_RATE / 2;
  localparam int BW   = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] OS_LAST = CW'(OS_RATE - 1);
  localparam logic [CW-1:0] OS_MID  = CW'(HALF - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     os_q;
  logic [BW-1:0]     bit_q;
  logic [BW-1:0]     nbits;
  logic [4:0]        want;
  logic [DATA_W-1:0] data_q;
  logic              acc_q;
  logic              par_on;

  assign want   = {1'b0, cfg_dbits} + 5'd3;
  assign par_on = cfg_par[1];

  always_comb begin
    if (want < 5'd5)                 nbits = BW'(5);
    else if (want > 5'(DATA_W))      nbits = BW'(DATA_W);
    else                             nbits = want[BW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      data_q  <= '0;
      acc_q   <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state_q <= S_IDLE;
        os_q    <= '0;
      end else if (tick) begin
        case (state_q)
          S_IDLE: begin
            if (!line) begin
              state_q <= S_START;
              os_q    <= '0;
            end
          end
          S_START: begin
            if (os_q == OS_MID) begin
              os_q <= '0;
              if (!line) begin
                state_q <= S_DATA;
                bit_q   <= '0;
                data_q  <= '0;
                acc_q   <= 1'b0;
              end else begin
                state_q <= S_IDLE;
              end
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_DATA: begin
            if (os_q == OS_LAST) begin
              os_q          <= '0;
              data_q[bit_q] <= line;
              acc_q         <= acc_q ^ line;
              if (bit_q == nbits - 1'b1) state_q <= par_on ? S_PAR : S_STOP;
              else                       bit_q   <= bit_q + 1'b1;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_PAR: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              acc_q   <= acc_q ^ line;
              state_q <= S_STOP;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_STOP: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              done    <= 1'b1;
              word    <= pack_word(data_q, par_on & (acc_q ^ cfg_par[0]), ~line);
              state_q <= cfg_stop2 ? S_SKIP : S_HOLD;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_SKIP: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              state_q <= S_HOLD;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_HOLD: begin
            if (line) state_q <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  // R5
  perr_needs_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_par[1]) |-> !word[PERR_POS]);

  // R2
  no_frame_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !done);

  // R3
  start_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !tick) |=> state_q == S_IDLE);
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] head,
  output logic             nonempty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_rd, do_wr;

  assign nonempty = (cnt_q != '0);
  assign full     = (cnt_q == CNT_FULL);
  assign do_rd    = rd && nonempty;
  assign do_wr    = wr && (!full || do_rd);
  assign head     = mem_q[rp_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_wr) begin
        mem_q[wp_q] <= wdata;
        wp_q        <= bump(wp_q);
      end
      if (do_rd) rp_q <= bump(rp_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> (full && $stable(head)));
endmodule

// File: rtl/uart_rx_tagged.sv
`timescale 1ns/1ps
module uart_rx_tagged
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DEPTH   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rxd,
  input  logic [3:0]  cfg_dbits,
  input  logic [1:0]  cfg_par,
  input  logic        cfg_stop2,
  input  logic        cmd_en,
  input  logic        cmd_dis,
  output logic [15:0] rx_word,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        ovf_flag,
  input  logic        ovf_clr
);
  logic     line_s;
  logic     on_q;
  logic     frame_done;
  rx_word_t frame_word;
  logic     fifo_full;
  logic     pop;

  assign pop = rx_valid && rx_ready;

  uart_rx_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       on_q <= 1'b0;
    else if (cmd_dis) on_q <= 1'b0;
    else if (cmd_en)  on_q <= 1'b1;
  end

  uart_rx_frame #(.OS_RATE(OS_RATE)) frame_i (
    .clk(clk), .rst_n(rst_n), .enable(on_q), .tick(os_tick), .line(line_s),
    .cfg_dbits(cfg_dbits), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .done(frame_done), .word(frame_word)
  );

  uart_rx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .wr(frame_done), .wdata(frame_word),
    .rd(pop), .head(rx_word), .nonempty(rx_valid), .full(fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ovf_flag <= 1'b0;
    else if (frame_done && fifo_full && !pop)     ovf_flag <= 1'b1;
    else if (ovf_clr)                             ovf_flag <= 1'b0;
  end

  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_word)));

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(frame_done && fifo_full && !pop));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: tb/uart_rx_tagged_tb.sv
`timescale 1ns/1ps
module uart_rx_tagged_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        os_tick = 1'b0;
  logic        rxd = 1'b1;
  logic [3:0]  cfg_dbits = 4'd5;
  logic [1:0]  cfg_par = 2'd0;
  logic        cfg_stop2 = 1'b0;
  logic        cmd_en = 1'b0;
  logic        cmd_dis = 1'b0;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        ovf_flag;
  logic        ovf_clr = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  uart_rx_tagged dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_dbits(cfg_dbits), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
  );

  initial forever #4 clk = ~clk;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      os_tick = (k % 4 == 0);
      k++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input int n, input int par,
                            input bit flip, input logic stop1, input bit two,
                            input logic stop2);
    logic p;
    p = 1'b0;
    bit_time(1'b0);
    for (int i = 0; i < n; i++) begin
      bit_time(d[i]);
      p = p ^ d[i];
    end
    if (par >= 2) begin
      if (par == 3) p = ~p;
      if (flip) p = ~p;
      bit_time(p);
    end
    bit_time(stop1);
    if (two) bit_time(stop2);
    rxd = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [15:0] exp);
    int w = 0;
    while (!rx_valid && w < 400) begin
      @(negedge clk);
      w++;
    end
    chk(req, 32'(rx_valid), 32'd1);
    chk(req, 32'(rx_word), 32'(exp));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    repeat (4) @(negedge clk);
    chk(req, 32'(rx_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", 32'(rx_valid), 32'd0);
    chk("R1 ovf after reset", 32'(ovf_flag), 32'd0);
    send_frame(9'h055, 8, 0, 0, 1'b1, 0, 1'b1);
    expect_empty("R1 off after reset");
    pulse(cmd_en);
  endtask

  task automatic t_formats;
    cfg_dbits = 4'd5; cfg_par = 2'd0;
    send_frame(9'h0A5, 8, 0, 0, 1'b1, 0, 1'b1);
    expect_word("R4 8N1", 16'h00A5);
    cfg_dbits = 4'd2;
    send_frame(9'h013, 5, 0, 0, 1'b1, 0, 1'b1);
    expect_word("R4 5-bit", 16'h0013);
    cfg_dbits = 4'd6;
    send_frame(9'h1A5, 9, 0, 0, 1'b1, 0, 1'b1);
    expect_word("R4 9-bit", 16'h01A5);
    cfg_dbits = 4'd0;
    send_frame(9'h00B, 5, 0, 0, 1'b1, 0, 1'b1);
    expect_word("R4 low code clamps to 5", 16'h000B);
    cfg_dbits = 4'd5;
    cfg_par = 2'd1;
    send_frame(9'h03C, 8, 0, 0, 1'b1, 0, 1'b1);
    expect_word("R5 code 1 is none", 16'h003C);
    cfg_par = 2'd0;
  endtask

  task automatic t_parity;
    cfg_dbits = 4'd5; cfg_par = 2'd2;
    send_frame(9'h035, 8, 2, 0, 1'b1, 0, 1'b1);
    expect_word("R5 even ok", 16'h0035);
    send_frame(9'h035, 8, 2, 1, 1'b1, 0, 1'b1);
    expect_word("R5 even bad", 16'h4035);
    cfg_dbits = 4'd4; cfg_par = 2'd3;
    send_frame(9'h041, 7, 3, 0, 1'b1, 0, 1'b1);
    expect_word("R5 odd ok", 16'h0041);
    send_frame(9'h041, 7, 3, 1, 1'b1, 0, 1'b1);
    expect_word("R5 odd bad", 16'h4041);
    cfg_dbits = 4'd5; cfg_par = 2'd0;
  endtask

  task automatic t_framing;
    send_frame(9'h05A, 8, 0, 0, 1'b0, 0, 1'b1);
    expect_word("R6 low stop", 16'h805A);
    cfg_stop2 = 1'b1;
    send_frame(9'h03C, 8, 0, 0, 1'b1, 1, 1'b0);
    expect_word("R6 second stop unchecked", 16'h003C);
    expect_empty("R6 no frame from second stop");
    send_frame(9'h03C, 8, 0, 0, 1'b0, 1, 1'b1);
    expect_word("R6 first stop checked", 16'h803C);
    cfg_stop2 = 1'b0;
  endtask

  task automatic t_break;
    rxd = 1'b0;
    repeat (12 * 64) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    expect_word("R7 break word", 16'h8000);
    expect_empty("R7 single break word");
    send_frame(9'h081, 8, 0, 0, 1'b1, 0, 1'b1);
    expect_word("R7 recovers after break", 16'h0081);
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    expect_empty("R3 short pulse rejected");
    send_frame(9'h0C3, 8, 0, 0, 1'b1, 0, 1'b1);
    expect_word("R3 normal after glitch", 16'h00C3);
  endtask

  task automatic t_enable;
    pulse(cmd_dis);
    send_frame(9'h0F0, 8, 0, 0, 1'b1, 0, 1'b1);
    expect_empty("R2 disabled ignores frame");
    cmd_en = 1'b1; cmd_dis = 1'b1;
    @(negedge clk);
    cmd_en = 1'b0; cmd_dis = 1'b0;
    send_frame(9'h0F0, 8, 0, 0, 1'b1, 0, 1'b1);
    expect_empty("R2 disable wins");
    pulse(cmd_en);
    send_frame(9'h00F, 8, 0, 0, 1'b1, 0, 1'b1);
    expect_word("R2 enabled again", 16'h000F);
  endtask

  task automatic t_overflow;
    logic [15:0] held;
    send_frame(9'h011, 8, 0, 0, 1'b1, 0, 1'b1);
    send_frame(9'h022, 8, 0, 0, 1'b1, 0, 1'b1);
    chk("R9 no ovf at two", 32'(ovf_flag), 32'd0);
    held = rx_word;
    send_frame(9'h033, 8, 0, 0, 1'b1, 0, 1'b1);
    chk("R9 ovf set", 32'(ovf_flag), 32'd1);
    chk("R8 head stable while stalled", 32'(rx_word), 32'(held));
    expect_word("R8 first in order", 16'h0011);
    expect_word("R8 second in order", 16'h0022);
    expect_empty("R9 third dropped");
    chk("R9 ovf sticky", 32'(ovf_flag), 32'd1);
    pulse(ovf_clr);
    chk("R9 ovf cleared", 32'(ovf_flag), 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_formats;
    t_parity;
    t_framing;
    t_break;
    t_glitch;
    t_enable;
    t_overflow;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule